// File: doc/BRIEF.md
# Serial Management Bus Master

This block drives the two-wire management bus that a MAC uses to reach the control and status registers of external PHYs. Software programs a small register file with four values: a PHY address, a register address, a data word for writes, and a command. The block then runs one serial management frame on the clock and data lines. It reports progress and results through a status word and a receive-data word.

The management clock comes from the system clock through a programmable divider that only accepts even ratios. The 32-bit preamble can be switched off for PHYs that accept frames without it. There are three commands:
- a one-shot register write;
- a one-shot register read;
- a continuous scan that keeps reading the PHY's basic status register and turns its link bit into a link-fail flag.

The data line is split into an output value, an output enable and an input. Open-drain or tristate merging is left to the pad ring.

The sequencer is a single state machine. Its states are:
- ST_IDLE: the line is released.
- ST_PREAMBLE: 32 driven ones.
- ST_START: bits 0 then 1.
- ST_OPCODE: 10 for a read, 01 for a write.
- ST_PHYADDR: five bits.
- ST_REGADDR: five bits.
- ST_TURN: two turnaround bits, released on a read and driven 1 then 0 on a write.
- ST_DATA: sixteen bits, released on a read.
- ST_FINISH: one released bit time.

The transitions, each taken on a falling MDC edge, are:
- IDLE→PREAMBLE when a command is pending and the preamble is on.
- IDLE→START when a command is pending and the preamble is off.
- PREAMBLE→START, START→OPCODE, OPCODE→PHYADDR, PHYADDR→REGADDR, REGADDR→TURN, TURN→DATA and DATA→FINISH, each after the last bit of its field.
- FINISH→IDLE unconditionally.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The mode register (select 0) holds the divider value in bits[7:0]. Bit 0 is always stored as 0. MDC has a period of that many system clocks, and values below 2 act as 2.
- R2: With mode bit 8 clear, every frame starts with 32 driven ones. With it set, the frame begins directly with the start bits.
- R3: A frame sends, MSB first: start bits 0,1; opcode 0,1 for a write or 1,0 for a read; the PHY address from address register bits[4:0]; the register address from bits[12:8]. A write then drives turnaround 1,0 followed by tx data register (select 3) bits[15:0].
- R4: On a read, the master releases the data line (enable low) during turnaround and the 16 data bits. After the read, the 16 received bits are in the rx data register (select 4).
- R5: The data output and its enable change only in system clock cycles in which MDC falls. The input is sampled when MDC rises.
- R6: The command register (select 1) uses bit 2 for write, bit 1 for read and bit 0 for scan. When several bits are set, write runs first, then read, then scan. The write and read bits clear themselves when their frame starts.
- R7: Status register (select 5) bit 1 (busy) is high from the command write until the last requested frame has finished, including while the scan bit stays set.
- R8: Scan reads register 1 of the PHY named in the address register, whatever the register field holds, and repeats the read frame after frame. Status bit 0 (link fail) is the inverse of bit 2 of the latest scan result.
- R9: Status bit 2 (invalid) rises when scan is switched on and falls when the first scan result has been captured.
- R10: After reset, the status and rx data registers read 0, the mode register reads 100 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The hardest situation to reach from the ports is the scan flag sequence: the invalid flag must fall at the first captured result, and the link-fail flag must follow a change of the PHY's link bit between two scan frames while the bus never goes idle. The bench gets there with a behavioural PHY that answers read frames from a register it can change at run time. The PHY reports link down first, then flips its link bit while scanning continues, and the bench polls the status word until each flag moves. Command priority is covered by writing the write and read bits together. The scoreboard then expects the write frame strictly before the read frame on the wire.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_SCAN  = 2'd3
    } mgmt_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_START,
        ST_OPCODE,
        ST_PHYADDR,
        ST_REGADDR,
        ST_TURN,
        ST_DATA,
        ST_FINISH
    } frame_state_e;

    localparam logic [2:0] SEL_MODE = 3'd0;
    localparam logic [2:0] SEL_CMD  = 3'd1;
    localparam logic [2:0] SEL_ADDR = 3'd2;
    localparam logic [2:0] SEL_TXD  = 3'd3;
    localparam logic [2:0] SEL_RXD  = 3'd4;
    localparam logic [2:0] SEL_STAT = 3'd5;

    localparam int CMD_SCAN_BIT  = 0;
    localparam int CMD_READ_BIT  = 1;
    localparam int CMD_WRITE_BIT = 2;

endpackage

// File: rtl/mdio_mdc_divider.sv
module mdio_mdc_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    localparam int HALF_W = DIV_W - 1;
    localparam logic [HALF_W-1:0] H_ONE = HALF_W'(1);

    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half;
    logic              wrap;

    always_comb begin
        half = div_i[DIV_W-1:1];
        if (half == '0) half = H_ONE;
    end

    assign wrap   = (cnt_q >= (half - H_ONE));
    assign rise_o = wrap & ~mdc_o;
    assign fall_o = wrap &  mdc_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_o <= ~mdc_o;
        end else begin
            cnt_q <= cnt_q + H_ONE;
        end
    end

    AST_RISE_RAISES_MDC: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> mdc_o); // R1

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int PRE_LEN  = 32,
    parameter int SCAN_REG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mdc_i,
    input  logic              nopre_i,
    input  logic              want_write_i,
    input  logic              want_read_i,
    input  logic              want_scan_i,
    input  logic [ADDR_W-1:0] phy_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] txd_i,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              launch_o,
    output mgmt_op_e          launch_op_o,
    output logic              done_o,
    output mgmt_op_e          done_op_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              active_o
);
    localparam int WIDEST = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
    localparam int IDX_W  = $clog2(WIDEST) + 1;
    localparam int AI_W   = $clog2(ADDR_W);
    localparam int DI_W   = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] I_ZERO = '0;
    localparam logic [IDX_W-1:0] I_ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] I_PRE  = IDX_W'(PRE_LEN - 1);
    localparam logic [IDX_W-1:0] I_ADDR = IDX_W'(ADDR_W - 1);
    localparam logic [IDX_W-1:0] I_DATA = IDX_W'(DATA_W - 1);

    frame_state_e      state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    mgmt_op_e          op_q, sel_op;
    logic [ADDR_W-1:0] phy_q, reg_q;
    logic [DATA_W-1:0] txd_q, sh_q;
    logic              want_any, last, is_wr;
    logic [IDX_W-1:0]  dec;

    assign want_any = want_write_i | want_read_i | want_scan_i;
    assign last     = (idx_q == I_ZERO);
    assign dec      = idx_q - I_ONE;
    assign is_wr    = (op_q == OP_WRITE);

    always_comb begin
        if (want_write_i)     sel_op = OP_WRITE;
        else if (want_read_i) sel_op = OP_READ;
        else if (want_scan_i) sel_op = OP_SCAN;
        else                  sel_op = OP_NONE;
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (fall_i) begin
            unique case (state_q)
                ST_IDLE: if (want_any) begin
                    if (nopre_i) begin state_d = ST_START;    idx_d = I_ONE; end
                    else         begin state_d = ST_PREAMBLE; idx_d = I_PRE; end
                end
                ST_PREAMBLE: if (last) begin state_d = ST_START;   idx_d = I_ONE;  end else idx_d = dec;
                ST_START:    if (last) begin state_d = ST_OPCODE;  idx_d = I_ONE;  end else idx_d = dec;
                ST_OPCODE:   if (last) begin state_d = ST_PHYADDR; idx_d = I_ADDR; end else idx_d = dec;
                ST_PHYADDR:  if (last) begin state_d = ST_REGADDR; idx_d = I_ADDR; end else idx_d = dec;
                ST_REGADDR:  if (last) begin state_d = ST_TURN;    idx_d = I_ONE;  end else idx_d = dec;
                ST_TURN:     if (last) begin state_d = ST_DATA;    idx_d = I_DATA; end else idx_d = dec;
                ST_DATA:     if (last) begin state_d = ST_FINISH;  idx_d = I_ZERO; end else idx_d = dec;
                ST_FINISH:   begin state_d = ST_IDLE; idx_d = I_ZERO; end
                default:     begin state_d = ST_IDLE; idx_d = I_ZERO; end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= I_ZERO;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // frame fields and receive shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_NONE;
            phy_q <= '0;
            reg_q <= '0;
            txd_q <= '0;
            sh_q  <= '0;
        end else begin
            if (launch_o) begin
                op_q  <= sel_op;
                phy_q <= phy_i;
                reg_q <= (sel_op == OP_SCAN) ? ADDR_W'(SCAN_REG) : reg_i;
                txd_q <= txd_i;
            end
            if (rise_i && state_q == ST_DATA && !is_wr)
                sh_q <= {sh_q[DATA_W-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        mdio_o    = 1'b0;
        mdio_oe_o = 1'b0;
        unique case (state_q)
            ST_PREAMBLE: begin mdio_oe_o = 1'b1; mdio_o = 1'b1; end
            ST_START:    begin mdio_oe_o = 1'b1; mdio_o = last; end
            ST_OPCODE:   begin mdio_oe_o = 1'b1; mdio_o = is_wr ? last : ~last; end
            ST_PHYADDR:  begin mdio_oe_o = 1'b1; mdio_o = phy_q[idx_q[AI_W-1:0]]; end
            ST_REGADDR:  begin mdio_oe_o = 1'b1; mdio_o = reg_q[idx_q[AI_W-1:0]]; end
            ST_TURN:     if (is_wr) begin mdio_oe_o = 1'b1; mdio_o = ~last; end
            ST_DATA:     if (is_wr) begin mdio_oe_o = 1'b1; mdio_o = txd_q[idx_q[DI_W-1:0]]; end
            default:     ;
        endcase
    end

    assign launch_o    = fall_i && (state_q == ST_IDLE) && want_any;
    assign launch_op_o = sel_op;
    assign done_o      = fall_i && (state_q == ST_DATA) && last;
    assign done_op_o   = op_q;
    assign rx_word_o   = sh_q;
    assign active_o    = (state_q != ST_IDLE);

    AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(mdio_o) || $changed(mdio_oe_o)) |-> $fell(mdc_i)); // R5
    AST_START_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(state_q) && state_q == ST_START) |->
            ($past(state_q) == ST_IDLE || $past(state_q) == ST_PREAMBLE)); // R2

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PRE_LEN   = 32,
    parameter int SCAN_REG  = 1,
    parameter int LINK_BIT  = 2,
    parameter int RESET_DIV = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);
    localparam int REG_LSB   = 8;
    localparam int NOPRE_BIT = DIV_W;

    logic [DIV_W-1:0]  div_q;
    logic              nopre_q;
    logic [2:0]        cmd_q;
    logic [ADDR_W-1:0] phy_q, rga_q;
    logic [DATA_W-1:0] txd_q, rxd_q;
    logic              link_fail_q, invalid_q, busy;
    logic              rise, fall, launch, done, active;
    mgmt_op_e          launch_op, done_op;
    logic [DATA_W-1:0] rx_word;
    logic              cmd_wr;
    logic              unused_wdata_hi;

    assign cmd_wr          = reg_we && (reg_sel == SEL_CMD);
    assign busy            = (|cmd_q) | active;
    assign unused_wdata_hi = ^reg_wdata[31:DATA_W];

    mdio_mdc_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_q),
        .mdc_o  (mdc_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_frame_engine #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PRE_LEN  (PRE_LEN),
        .SCAN_REG (SCAN_REG)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_i       (rise),
        .fall_i       (fall),
        .mdc_i        (mdc_o),
        .nopre_i      (nopre_q),
        .want_write_i (cmd_q[CMD_WRITE_BIT]),
        .want_read_i  (cmd_q[CMD_READ_BIT]),
        .want_scan_i  (cmd_q[CMD_SCAN_BIT]),
        .phy_i        (phy_q),
        .reg_i        (rga_q),
        .txd_i        (txd_q),
        .mdio_i       (mdio_i),
        .mdio_o       (mdio_o),
        .mdio_oe_o    (mdio_oe_o),
        .launch_o     (launch),
        .launch_op_o  (launch_op),
        .done_o       (done),
        .done_op_o    (done_op),
        .rx_word_o    (rx_word),
        .active_o     (active)
    );

    // software-written registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= DIV_W'(RESET_DIV) & ~DIV_W'(1);
            nopre_q <= 1'b0;
            phy_q   <= '0;
            rga_q   <= '0;
            txd_q   <= '0;
        end else if (reg_we) begin
            unique case (reg_sel)
                SEL_MODE: begin
                    div_q   <= {reg_wdata[DIV_W-1:1], 1'b0};
                    nopre_q <= reg_wdata[NOPRE_BIT];
                end
                SEL_ADDR: begin
                    phy_q <= reg_wdata[ADDR_W-1:0];
                    rga_q <= reg_wdata[REG_LSB +: ADDR_W];
                end
                SEL_TXD: txd_q <= reg_wdata[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    // command bits: one-shot read/write clear on launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_wr) begin
            cmd_q <= reg_wdata[2:0];
        end else if (launch) begin
            if (launch_op == OP_WRITE)     cmd_q[CMD_WRITE_BIT] <= 1'b0;
            else if (launch_op == OP_READ) cmd_q[CMD_READ_BIT]  <= 1'b0;
        end
    end

    // results and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_q       <= '0;
            link_fail_q <= 1'b0;
            invalid_q   <= 1'b0;
        end else begin
            if (done && done_op != OP_WRITE) rxd_q <= rx_word;
            if (done && done_op == OP_SCAN) link_fail_q <= ~rx_word[LINK_BIT];
            if (cmd_wr && reg_wdata[CMD_SCAN_BIT] && !cmd_q[CMD_SCAN_BIT])
                invalid_q <= 1'b1;
            else if (done && done_op == OP_SCAN)
                invalid_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_MODE: reg_rdata = 32'({nopre_q, div_q});
            SEL_CMD:  reg_rdata = 32'(cmd_q);
            SEL_ADDR: begin
                reg_rdata[ADDR_W-1:0]        = phy_q;
                reg_rdata[REG_LSB +: ADDR_W] = rga_q;
            end
            SEL_TXD:  reg_rdata = 32'(txd_q);
            SEL_RXD:  reg_rdata = 32'(rxd_q);
            SEL_STAT: reg_rdata = 32'({invalid_q, busy, link_fail_q});
            default:  reg_rdata = '0;
        endcase
    end

    AST_INVALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(invalid_q) |-> $past(done && done_op == OP_SCAN)); // R9
    AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && launch_op == OP_READ && !cmd_wr) |=> !cmd_q[CMD_READ_BIT]); // R6
    AST_BUSY_THROUGH_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> busy); // R7

endmodule

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
    import mdio_mgmt_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    wire  [31:0] reg_rdata;
    wire         mdc, mdio_o, mdio_oe;
    logic        phy_oe = 1'b0, phy_out = 1'b0;
    wire         mdio_i = phy_oe ? phy_out : (mdio_oe ? mdio_o : 1'b1);
    wire         line_v = mdio_oe ? mdio_o : 1'b1;

    mdio_mgmt_master dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_o(mdc),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
    );

    int n_cmp = 0, n_bad = 0, edge_viol = 0, scan_frames = 0, scan_pre = 0;
    bit done_flag = 1'b0, scan_exp = 1'b0;
    logic [4:0]  scan_phy = '0;
    logic [15:0] reg1_val = '0;

    typedef struct {
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] data;
        int          pre;
    } frame_t;
    frame_t exp_q[$];

    function automatic logic [15:0] phy_data(input logic [4:0] p, input logic [4:0] r);
        if (r == 5'd1) return reg1_val;
        return {3'b101, p, r, 3'b011};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        v = 32'hffff_ffff;
        for (int i = 0; i < 20000; i++) begin
            rd(SEL_STAT, v);
            if (!v[1]) break;
        end
        check(!v[1], tag, v, 0);
    endtask

    task automatic push(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] d, input int pre);
        frame_t e;
        e.op = op; e.phy = p; e.rg = r; e.data = d; e.pre = pre;
        exp_q.push_back(e);
    endtask

    task automatic measure(output int cyc);
        time t0;
        @(posedge mdc); @(posedge mdc);
        t0 = $time;
        @(posedge mdc);
        cyc = int'(($time - t0) / 8);
    endtask

    // R5: data line moves only where MDC falls
    initial begin
        logic po, poe, pm;
        po = 1'b0; poe = 1'b0; pm = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (mdio_o !== po || mdio_oe !== poe) && !(pm && !mdc)) edge_viol++;
            po = mdio_o; poe = mdio_oe; pm = mdc;
        end
    end

    // PHY model and scoreboard monitor
    initial begin
        int pre;
        bit rel_ok;
        logic s1;
        logic [1:0] op, ta;
        logic [4:0] p, r;
        logic [15:0] d;
        frame_t e;
        forever begin
            pre = 0;
            forever begin
                @(posedge mdc);
                if (mdio_oe && mdio_o) pre++;
                else if (mdio_oe && !mdio_o) break;
                else pre = 0;
            end
            @(posedge mdc); s1 = line_v;
            op = '0; p = '0; r = '0; d = '0; ta = '0;
            for (int i = 0; i < 2; i++) begin @(posedge mdc); op = {op[0], line_v}; end
            for (int i = 0; i < 5; i++) begin @(posedge mdc); p = {p[3:0], line_v}; end
            for (int i = 0; i < 5; i++) begin @(posedge mdc); r = {r[3:0], line_v}; end
            check(s1 == 1'b1, "R3 second start bit", 32'(s1), 1);
            if (op == 2'b10) begin
                d = phy_data(p, r);
                rel_ok = 1'b1;
                @(negedge mdc); phy_oe = 1'b0;
                @(posedge mdc); if (mdio_oe) rel_ok = 1'b0;
                @(negedge mdc); phy_oe = 1'b1; phy_out = 1'b0;
                @(posedge mdc); if (mdio_oe) rel_ok = 1'b0;
                for (int i = 15; i >= 0; i--) begin
                    @(negedge mdc); phy_out = d[i];
                    @(posedge mdc); if (mdio_oe) rel_ok = 1'b0;
                end
                @(negedge mdc); phy_oe = 1'b0;
                check(rel_ok, "R4 line released during read", 32'(rel_ok), 1);
            end else begin
                for (int i = 0; i < 2; i++) begin @(posedge mdc); ta = {ta[0], line_v}; end
                for (int i = 0; i < 16; i++) begin @(posedge mdc); d = {d[14:0], line_v}; end
                check(ta == 2'b10, "R3 write turnaround", 32'(ta), 32'h2);
            end
            if (scan_exp && exp_q.size() == 0) begin
                scan_frames++;
                check(op == 2'b10 && p == scan_phy && r == 5'd1, "R8 scan frame target",
                      {op, p, r}, {2'b10, scan_phy, 5'd1});
                check(pre == scan_pre, "R2 scan preamble length", pre, scan_pre);
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected frame", {op, p, r}, 0);
            end else begin
                e = exp_q.pop_front();
                check(op == e.op && p == e.phy && r == e.rg, "R3 op/phy/reg fields",
                      {op, p, r}, {e.op, e.phy, e.rg});
                check(d == e.data, "R3 frame data", d, e.data);
                check(pre == e.pre, "R2 preamble length", pre, e.pre);
            end
        end
    end

    // watchdog
    initial begin
        #(8 * 150000);
        if (!done_flag) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cyc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(SEL_STAT, v); check(v == 0, "R10 status after reset", v, 0);
        rd(SEL_RXD, v);  check(v == 0, "R10 rx data after reset", v, 0);
        rd(SEL_MODE, v); check(v == 100, "R10 mode after reset", v, 100);
        check(mdio_oe == 1'b0, "R10 line released after reset", 32'(mdio_oe), 0);

        // R1 divider
        wr(SEL_MODE, 32'h5);
        rd(SEL_MODE, v); check(v == 32'h4, "R1 odd divider forced even", v, 4);
        measure(cyc);    check(cyc == 4, "R1 MDC period div4", cyc, 4);
        wr(SEL_MODE, 32'h6);
        measure(cyc);    check(cyc == 6, "R1 MDC period div6", cyc, 6);
        wr(SEL_MODE, 32'h0);
        measure(cyc);    check(cyc == 2, "R1 MDC period minimum", cyc, 2);
        wr(SEL_MODE, 32'h4);

        // R3/R2 write frame with preamble, R7 busy
        wr(SEL_ADDR, (32'h1A << 8) | 32'h03);
        wr(SEL_TXD, 32'hBEEF);
        push(2'b01, 5'h03, 5'h1A, 16'hBEEF, 32);
        wr(SEL_CMD, 32'h4);
        rd(SEL_STAT, v); check(v[1] == 1'b1, "R7 busy after command", v, 2);
        wait_idle("R7 busy clears after write");
        rd(SEL_CMD, v);  check(v == 0, "R6 write bit self-clears", v, 0);

        // R4 read frame
        wr(SEL_ADDR, (32'h05 << 8) | 32'h11);
        push(2'b10, 5'h11, 5'h05, phy_data(5'h11, 5'h05), 32);
        wr(SEL_CMD, 32'h2);
        wait_idle("R7 busy clears after read");
        rd(SEL_RXD, v);  check(v == 32'(phy_data(5'h11, 5'h05)), "R4 rx data captured", v, 32'(phy_data(5'h11, 5'h05)));

        // R2 no preamble
        wr(SEL_MODE, 32'h104);
        wr(SEL_ADDR, (32'h09 << 8) | 32'h02);
        push(2'b10, 5'h02, 5'h09, phy_data(5'h02, 5'h09), 0);
        wr(SEL_CMD, 32'h2);
        wait_idle("R7 busy clears after short read");
        rd(SEL_RXD, v);  check(v == 32'(phy_data(5'h02, 5'h09)), "R2 rx data without preamble", v, 32'(phy_data(5'h02, 5'h09)));

        // R6 priority: write before read
        wr(SEL_ADDR, (32'h1A << 8) | 32'h03);
        wr(SEL_TXD, 32'h1234);
        push(2'b01, 5'h03, 5'h1A, 16'h1234, 0);
        push(2'b10, 5'h03, 5'h1A, phy_data(5'h03, 5'h1A), 0);
        wr(SEL_CMD, 32'h6);
        wait_idle("R7 busy spans both frames");
        rd(SEL_CMD, v);  check(v == 0, "R6 both one-shot bits cleared", v, 0);
        check(exp_q.size() == 0, "R6 write then read consumed in order", exp_q.size(), 0);
        rd(SEL_RXD, v);  check(v == 32'(phy_data(5'h03, 5'h1A)), "R6 read after write data", v, 32'(phy_data(5'h03, 5'h1A)));

        // R8/R9 scan
        reg1_val = 16'h0000;
        scan_phy = 5'h04; scan_pre = 0; scan_exp = 1'b1;
        wr(SEL_ADDR, (32'h07 << 8) | 32'h04);
        wr(SEL_CMD, 32'h1);
        rd(SEL_STAT, v); check(v[2:1] == 2'b11, "R9 invalid and busy at scan start", v, 6);
        for (int i = 0; i < 20000; i++) begin rd(SEL_STAT, v); if (!v[2]) break; end
        check(v[2] == 1'b0, "R9 invalid clears after first result", v, 0);
        check(v[0] == 1'b1, "R8 link fail with link bit low", v, 1);
        reg1_val = 16'h0004;
        for (int i = 0; i < 20000; i++) begin rd(SEL_STAT, v); if (!v[0]) break; end
        check(v[0] == 1'b0, "R8 link fail follows link bit", v, 0);
        check(v[1] == 1'b1, "R7 busy while scanning", v, 2);
        rd(SEL_RXD, v);  check(v == 32'h4, "R8 scan result in rx data", v, 4);
        wr(SEL_CMD, 32'h0);
        wait_idle("R7 busy clears after scan stop");
        scan_exp = 1'b0;
        check(scan_frames >= 2, "R8 scan repeats", scan_frames, 2);

        check(edge_viol == 0, "R5 line changes only on MDC fall", edge_viol, 0);

        done_flag = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule